// File: doc/BRIEF.md
# Shared-DAC Successive-Approximation Sequencer

This block is the digital controller of an 8-bit successive-approximation ADC that owns no comparison DAC of its own. It borrows the single ladder DAC that also drives the chip's analog output. When a conversion is requested, the block freezes the output buffer's track-and-hold so that the user-visible voltage does not move. It then drives its own trial codes onto the DAC and runs a binary search against a comparator bit. When the search ends, it puts the user code back on the DAC, lets the buffer track again and reports the result.

Between conversions the DAC simply follows the user code register. The comparator, the resistor ladder and the channel multiplexer that picks one of four single-ended or differential inputs all sit outside this block. The comparator reports 1 when the selected input is at or above the level that the present DAC code produces.

Top module: `shared_dac_sar`

## Requirements
- R1: While reset is high and just after it, hold_o, busy_o and done_o are 0, result_o is 0, and dac_code_o takes the value of user_code_i.
- R2: While idle (busy_o low), dac_code_o copies user_code_i with one clock of latency.
- R3: A start_i sampled high while idle sets hold_o and busy_o at that edge. dac_code_o then keeps the user code for one further clock before the first trial code appears.
- R4: The search runs from the most significant bit down to bit 0. Step i drives the code formed by the bits already decided, plus bit W-1-i set, with all lower bits 0. The first trial is therefore 0x80 for W=8.
- R5: A trial code is held on dac_code_o for 1+SETTLE_CYC clocks. The trial bit is then kept if cmp_i is 1 (input at or above the DAC level) and cleared if cmp_i is 0.
- R6: For any input level v in 0..255 with an ideal comparator (cmp_i = v >= dac_code_o), result_o equals v.
- R7: After the last step, dac_code_o is loaded with the current user_code_i, including a value changed during the conversion. hold_o falls exactly one clock later.
- R8: done_o is a single-clock pulse. It rises 4 + W*(2+SETTLE_CYC) edges after the start edge (28 by default) and one edge after hold_o falls. result_o changes only on that edge and holds its value until the next done_o.
- R9: A start_i raised while busy_o is high is ignored: the conversion keeps its timing and result, and no second done_o follows.
- R10: hold_o is never high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| user_code_i | input | W | User output code from the DAC data register |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | W | Code driven to the shared ladder DAC |
| hold_o | output | 1 | Freeze command for the output buffer's track-and-hold |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock pulse when result_o is new |
| result_o | output | W | Conversion result |

## Verification
All results have fixed latencies counted in edges from the edge that samples start_i: hold at edge 0, the first trial code at edge 2, step i at edge 2+3i, the restored user code at edge 26, hold release at 27 and done at 28.

The bench counts falling edges after the start edge and compares each output at the falling edge that follows the rising edge where it is due, so every value is read half a period after it settles. The comparator is modelled as a combinational function of dac_code_o, and every input level from 0 to 255 is swept.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_TRY,
    S_SETTLE,
    S_DECIDE,
    S_RESTORE,
    S_RELEASE,
    S_FIN
  } seq_state_e;

  // Total edges from the start edge to the done edge.
  function automatic int conv_latency(input int w, input int settle);
    return 4 + w * (2 + settle);
  endfunction

endpackage

// File: rtl/sar_bit_walker.sv
module sar_bit_walker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  output logic [W-1:0] mask_o,
  output logic         last_o
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
    end else if (load) begin
      mask_o <= TOP_BIT;
    end else if (shift) begin
      mask_o <= mask_o >> 1;
    end
  end

  assign last_o = mask_o[0];

endmodule

// File: rtl/sar_trial_acc.sv
module sar_trial_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         commit,
  input  logic         keep,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] trial_o
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_o <= '0;
    end else if (commit && keep) begin
      acc_o <= acc_o | mask_i;
    end
  end

  assign trial_o = acc_o | mask_i;

endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int N = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired_o
);

  generate
    if (N <= 1) begin : g_single
      logic unused_pins;
      assign unused_pins = clk ^ rst ^ arm;
      assign expired_o   = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(N);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (arm) begin
          cnt_q <= CW'(N - 1);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      assign expired_o = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/shared_dac_sar.sv
module shared_dac_sar #(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] user_code_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_code_o,
  output logic         hold_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  import sar_pkg::*;

  seq_state_e   state_q;
  logic [W-1:0] mask;
  logic [W-1:0] acc;
  logic [W-1:0] trial;
  logic         last_bit;
  logic         settle_done;
  logic         walk_load;
  logic         walk_shift;
  logic         acc_commit;
  logic         timer_arm;
  logic         settling;

  always_comb begin
    walk_load  = (state_q == S_HOLD);
    walk_shift = (state_q == S_DECIDE) && !last_bit;
    acc_commit = (state_q == S_DECIDE);
    timer_arm  = (state_q == S_TRY);
    settling   = (state_q == S_SETTLE);
  end

  sar_bit_walker #(.W(W)) u_walker (
    .clk    (clk),
    .rst    (rst),
    .load   (walk_load),
    .shift  (walk_shift),
    .mask_o (mask),
    .last_o (last_bit)
  );

  sar_trial_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear   (walk_load),
    .commit  (acc_commit),
    .keep    (cmp_i),
    .mask_i  (mask),
    .acc_o   (acc),
    .trial_o (trial)
  );

  sar_settle_timer #(.N(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .arm       (timer_arm),
    .expired_o (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      hold_o     <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
      dac_code_o <= user_code_i;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          dac_code_o <= user_code_i;
          if (start_i) begin
            hold_o  <= 1'b1;
            busy_o  <= 1'b1;
            state_q <= S_HOLD;
          end
        end
        S_HOLD: state_q <= S_TRY;
        S_TRY: begin
          dac_code_o <= trial;
          state_q    <= S_SETTLE;
        end
        S_SETTLE: begin
          if (settle_done) state_q <= S_DECIDE;
        end
        S_DECIDE: state_q <= last_bit ? S_RESTORE : S_TRY;
        S_RESTORE: begin
          dac_code_o <= user_code_i;
          state_q    <= S_RELEASE;
        end
        S_RELEASE: begin
          hold_o  <= 1'b0;
          state_q <= S_FIN;
        end
        S_FIN: begin
          done_o   <= 1'b1;
          result_o <= acc;
          busy_o   <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] user_code_i,
  input logic [W-1:0] dac_code_o,
  input logic         hold_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic         settling
);

  logic [1:0] age = 2'd0;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$past(busy_o)) |-> dac_code_o == $past(user_code_i));

  // R3
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $rose(hold_o)) |=> $stable(dac_code_o));

  // R5
  settle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    settling |=> $stable(dac_code_o));

  // R7
  restore_first_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $fell(hold_o)) |-> $stable(dac_code_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && done_o) |-> (!hold_o && !$past(hold_o) && $past(hold_o, 2)));

  // R8
  result_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !done_o) |-> $stable(result_o));

  // R10
  hold_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> busy_o);

endmodule

bind shared_dac_sar sar_seq_chk #(.W(W)) u_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .user_code_i (user_code_i),
  .dac_code_o  (dac_code_o),
  .hold_o      (hold_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .settling    (settling)
);

// File: tb/tb_shared_dac_sar.sv
`timescale 1ns/1ps
module tb_shared_dac_sar;
  localparam int W   = 8;
  localparam int S   = 1;
  localparam int LAT = 4 + W * (2 + S);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] user_code = 8'h5A;
  logic [W-1:0] vin = '0;
  logic         cmp;
  logic [W-1:0] dac_code;
  logic         hold, busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign cmp = (vin >= dac_code);

  shared_dac_sar #(.W(W), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst(rst), .start_i(start), .user_code_i(user_code),
    .cmp_i(cmp), .dac_code_o(dac_code), .hold_o(hold), .busy_o(busy),
    .done_o(done), .result_o(result)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One conversion; optional start during busy at intrude_k and user code change at 5.
  task automatic convert(input logic [W-1:0] v, input logic [W-1:0] u,
                         input int intrude_k, input bit change_user,
                         input logic [W-1:0] new_u);
    logic [W-1:0] exp_user;
    exp_user = u;
    @(negedge clk);
    vin = v; user_code = u; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R3: hold and busy set at the start edge, user code still on the DAC
    check("R3 hold", int'(hold), 1);
    check("R3 busy", int'(busy), 1);
    check("R3 dac", int'(dac_code), int'(u));
    for (int k = 1; k <= LAT + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k == 1) check("R3 dac held", int'(dac_code), int'(u));
      for (int i = 0; i < W; i++) begin
        if (k == 2 + (2 + S) * i) begin
          int m;
          m = ((1 << W) - 1) & ~((1 << (W - i)) - 1);
          // R4 trial order and R5 bit decisions
          check(i == 0 ? "R4 first trial" : "R5 trial", int'(dac_code),
                (int'(v) & m) | (1 << (W - 1 - i)));
        end
      end
      if (change_user && k == 5) begin
        user_code = new_u;
        exp_user  = new_u;
      end
      if (intrude_k != 0 && k == intrude_k) start = 1'b1;
      if (k == LAT - 2) begin
        check("R7 restored", int'(dac_code), int'(exp_user));
        check("R7 hold kept", int'(hold), 1);
      end
      if (k == LAT - 1) check("R7 hold fell", int'(hold), 0);
      if (k < LAT) check("R8 no early done", int'(done), 0);
      if (k == LAT) begin
        check("R8 done", int'(done), 1);
        check("R6 result", int'(result), int'(v));
        check("R8 busy low", int'(busy), 0);
      end
      if (k == LAT + 1) begin
        check("R8 done one cycle", int'(done), 0);
        check("R8 result held", int'(result), int'(v));
      end
    end
  endtask

  initial begin
    int extra_done;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 hold", int'(hold), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 dac", int'(dac_code), 8'h5A);
    rst = 1'b0;

    // R2 idle follow
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      user_code = 8'(j * 67 + 3);
      @(posedge clk);
      @(negedge clk);
      check("R2 follow", int'(dac_code), int'(user_code));
    end

    // R6 exhaustive sweep
    for (int v = 0; v < 256; v++) convert(8'(v), 8'(255 - v), 0, 1'b0, 8'h00);

    // R7 user code changed mid conversion
    convert(8'h9C, 8'h11, 0, 1'b1, 8'hE4);

    // R9 start while busy ignored
    convert(8'h37, 8'hA0, 10, 1'b0, 8'h00);
    convert(8'hFE, 8'h01, LAT - 1, 1'b0, 8'h00);
    extra_done = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (done) extra_done++;
    end
    check("R9 no extra done", extra_done, 0);
    check("R9 idle", int'(busy), 0);
    check("R10 hold idle", int'(hold), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule